// File: doc/BRIEF.md
# Dot-Matrix Column Intensity Modulator

This block produces the column drive timing for an eight-character dot-matrix display. A master tick comes either from a free-running internal divider of the system clock or from rising edges on an external clock pin. The internal divider lets several displays share one clock. A counter chain turns the master tick into a digit-multiplex strobe and a slow blink phase. A 15-slot frame counter drives a duty-cycle gate, so that brightness is set by the fraction of time the columns are on, never by the drive strength.

The control word sets four things: the brightness level, per-character flashing, whole-display blinking and a lamp test. The block combines these with one flash bit per character and produces a registered column-enable bit for each character. The font lookup and the row drivers sit outside this block. They sample the enables, the multiplex strobe and the blink phase.

Top module: `dcm_modulator`

## Requirements
- R1: When `clk_sel` is 1, the master tick fires once every `OSC_DIV` system clocks. When `clk_sel` is 0, it fires once for each rising edge of `ext_clk`, seen through a two-flop synchronizer.
- R2: `mux_tick` is a single-cycle pulse that repeats every `PRE_DIV*MUX_DIV` master ticks (32*7 = 224). The first pulse after reset comes exactly 224 master ticks after reset is released.
- R3: `blink_phase` is 1 after reset. It stays 1 for `BLINK_DIV/2` multiplex periods and then 0 for the same span, so one full blink cycle is 128 multiplex periods. It changes only in the cycle after a `mux_tick` pulse.
- R4: Control bits [2:0] select the brightness. In each 15-slot frame of master ticks, codes 0..7 enable 15, 12, 8, 6, 4, 3, 2 and 0 slots.
- R5: When control bit 3 is 1, a character whose flash bit is 1 is dark while `blink_phase` is 0. When control bit 3 is 0, the flash bits have no effect.
- R6: When control bit 4 is 1, all characters are dark while `blink_phase` is 0, whatever the flash settings.
- R7: When control bit 6 (lamp test) is 1, every character is enabled for exactly 8 of 15 slots. This holds for any brightness code and overrides flash and blink.
- R8: While reset is high, `col_en` is all zero, `mux_tick` is 0 and every counter restarts from zero, so displays that share a clock stay in phase.
- R9: When the selected clock source gives no ticks, `col_en`, `mux_tick` and `blink_phase` hold their values.
- R10: Control bits 5 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 1 | 1: internal divider drives the master tick; 0: external clock drives it |
| ext_clk | input | 1 | External master clock, asynchronous to `clk` |
| ctrl | input | 8 | Control word: [2:0] brightness, 3 flash enable, 4 blink, 6 lamp test |
| flash | input | NCHAR | Per-character flash bits |
| col_en | output | NCHAR | Registered column enable for each character |
| mux_tick | output | 1 | Digit-multiplex strobe, one cycle wide |
| blink_phase | output | 1 | 2 Hz blink phase, 1 = visible half |

## Verification
Brightness is checked by counting enabled cycles over a whole frame for every code. The count does not depend on where the frame starts, so it tells the duty table apart from the frame alignment. The same counts are then repeated in the dark and the visible blink halves, with flash enable, blink and lamp test mixed in random and directed combinations. This separates per-character gating from whole-display gating and from the lamp override. Divider ratios are measured as the spacing between strobes and between phase edges, from both clock sources. A stopped external clock confirms that every output freezes.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  localparam int FRAME_SLOTS = 15;
  localparam int LAMP_SLOTS  = 8;
  localparam int CW_FLASH    = 3;
  localparam int CW_BLINK    = 4;
  localparam int CW_LAMP     = 6;

  // enabled slots per frame for each brightness code
  function automatic int level_slots(input logic [2:0] code);
    case (code)
      3'd0:    return 15;
      3'd1:    return 12;
      3'd2:    return 8;
      3'd3:    return 6;
      3'd4:    return 4;
      3'd5:    return 3;
      3'd6:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/dcm_clk_src.sv
module dcm_clk_src #(
  parameter int OSC_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_sel,
  input  logic ext_clk,
  output logic mtick
);
  localparam int OSC_W = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
  localparam logic [OSC_W-1:0] OSC_LAST = OSC_W'(OSC_DIV - 1);

  logic [OSC_W-1:0] osc_cnt;
  logic [2:0]       ext_sh;
  logic             osc_tick;
  logic             ext_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_cnt <= '0;
      ext_sh  <= '0;
    end else begin
      osc_cnt <= (osc_cnt == OSC_LAST) ? '0 : osc_cnt + 1'b1;
      ext_sh  <= {ext_sh[1:0], ext_clk};
    end
  end

  assign osc_tick = (osc_cnt == OSC_LAST);
  assign ext_rise = ext_sh[1] & ~ext_sh[2];
  assign mtick    = ~rst & (clk_sel ? osc_tick : ext_rise);
endmodule

// File: rtl/dcm_timebase.sv
module dcm_timebase #(
  parameter int PRE_DIV   = 32,
  parameter int MUX_DIV   = 7,
  parameter int BLINK_DIV = 128,
  parameter int FRAME     = 15,
  parameter int SLOT_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mtick,
  output logic [SLOT_W-1:0] slot,
  output logic              mux_hit,
  output logic              blink_on
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int MUX_W = (MUX_DIV > 1) ? $clog2(MUX_DIV) : 1;
  localparam int BLK_W = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
  localparam logic [BLK_W-1:0] BLK_HALF = BLK_W'(BLINK_DIV / 2);

  logic [PRE_W-1:0] pre;
  logic [MUX_W-1:0] mux;
  logic [BLK_W-1:0] blk;
  logic pre_last, mux_last, blk_last, slot_last;

  assign pre_last  = (pre  == PRE_W'(PRE_DIV - 1));
  assign mux_last  = (mux  == MUX_W'(MUX_DIV - 1));
  assign blk_last  = (blk  == BLK_W'(BLINK_DIV - 1));
  assign slot_last = (slot == SLOT_W'(FRAME - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre  <= '0;
      mux  <= '0;
      blk  <= '0;
      slot <= '0;
    end else if (mtick) begin
      slot <= slot_last ? '0 : slot + 1'b1;
      pre  <= pre_last ? '0 : pre + 1'b1;
      if (pre_last)
        mux <= mux_last ? '0 : mux + 1'b1;
      if (pre_last && mux_last)
        blk <= blk_last ? '0 : blk + 1'b1;
    end
  end

  assign mux_hit  = mtick & pre_last & mux_last;
  assign blink_on = (blk < BLK_HALF);
endmodule

// File: rtl/dcm_duty.sv
module dcm_duty
  import dcm_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [2:0]        code,
  output logic              dim_on,
  output logic              lamp_on
);
  always_comb begin
    dim_on  = (int'(slot) < level_slots(code));
    lamp_on = (int'(slot) < LAMP_SLOTS);
  end
endmodule

// File: rtl/dcm_modulator.sv
module dcm_modulator
  import dcm_pkg::*;
#(
  parameter int NCHAR     = 8,
  parameter int OSC_DIV   = 4,
  parameter int PRE_DIV   = 32,
  parameter int MUX_DIV   = 7,
  parameter int BLINK_DIV = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_sel,
  input  logic             ext_clk,
  input  logic [7:0]       ctrl,
  input  logic [NCHAR-1:0] flash,
  output logic [NCHAR-1:0] col_en,
  output logic             mux_tick,
  output logic             blink_phase
);
  localparam int SLOT_W = $clog2(FRAME_SLOTS);

  logic              mtick, mux_hit, blink_on, dim_on, lamp_on;
  logic [SLOT_W-1:0] slot;
  logic [NCHAR-1:0]  col_nx;
  logic              ign_unused;

  assign ign_unused = ctrl[7] ^ ctrl[5];

  dcm_clk_src #(.OSC_DIV(OSC_DIV)) u_src (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .ext_clk(ext_clk), .mtick(mtick)
  );

  dcm_timebase #(
    .PRE_DIV(PRE_DIV), .MUX_DIV(MUX_DIV), .BLINK_DIV(BLINK_DIV),
    .FRAME(FRAME_SLOTS), .SLOT_W(SLOT_W)
  ) u_tb (
    .clk(clk), .rst(rst), .mtick(mtick), .slot(slot),
    .mux_hit(mux_hit), .blink_on(blink_on)
  );

  dcm_duty #(.SLOT_W(SLOT_W)) u_duty (
    .slot(slot), .code(ctrl[2:0]), .dim_on(dim_on), .lamp_on(lamp_on)
  );

  for (genvar i = 0; i < NCHAR; i++) begin : g_char
    logic dark;
    assign dark      = ~blink_on & (ctrl[CW_BLINK] | (ctrl[CW_FLASH] & flash[i]));
    assign col_nx[i] = ctrl[CW_LAMP] ? lamp_on : (dim_on & ~dark);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_en      <= '0;
      mux_tick    <= 1'b0;
      blink_phase <= 1'b1;
    end else begin
      col_en      <= col_nx;
      mux_tick    <= mux_hit;
      blink_phase <= blink_on;
    end
  end
endmodule

// File: rtl/dcm_checks.sv
module dcm_checks #(
  parameter int NCHAR = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       ctrl,
  input logic [NCHAR-1:0] col_en,
  input logic             mux_tick,
  input logic             blink_phase
);
  p_lamp_uniform_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl[6] |=> (col_en == '0 || col_en == '1));

  p_blank_dark_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[6] && ctrl[2:0] == 3'b111) |=> col_en == '0);

  p_full_on_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[6] && !ctrl[4] && !ctrl[3] && ctrl[2:0] == 3'b000) |=> col_en == '1);

  p_blink_dark_r6: assert property (@(posedge clk) disable iff (rst)
    (!blink_phase && $past(ctrl[4]) && !$past(ctrl[6])) |-> col_en == '0);

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    mux_tick |=> !mux_tick);

  p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(blink_phase) |-> $past(mux_tick));

  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |=> (col_en == '0 && !mux_tick));
endmodule

bind dcm_modulator dcm_checks #(.NCHAR(NCHAR)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl), .col_en(col_en),
  .mux_tick(mux_tick), .blink_phase(blink_phase)
);

// File: tb/dcm_modulator_bench.sv
module dcm_modulator_bench;
  localparam int NCHAR = 8;
  localparam int STRB  = 32 * 7;

  logic             clk = 1'b0, rst = 1'b1, clk_sel = 1'b1, ext_clk = 1'b0;
  logic [7:0]       ctrl = '0;
  logic [NCHAR-1:0] flash = '0;
  logic [NCHAR-1:0] col_en;
  logic             mux_tick, blink_phase;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit ext_run = 1'b0;
  int cnt [NCHAR];

  dcm_modulator #(.NCHAR(NCHAR), .OSC_DIV(1)) u_dcm_modulator (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .ext_clk(ext_clk), .ctrl(ctrl),
    .flash(flash), .col_en(col_en), .mux_tick(mux_tick), .blink_phase(blink_phase)
  );

  always #2 clk = ~clk;

  initial forever begin
    #8;
    if (ext_run) ext_clk = ~ext_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  function automatic int lvl(input bit [2:0] c);
    case (c)
      3'd0: return 15; 3'd1: return 12; 3'd2: return 8; 3'd3: return 6;
      3'd4: return 4;  3'd5: return 3;  3'd6: return 2; default: return 0;
    endcase
  endfunction

  function automatic int exp_n(input bit [7:0] cw, input bit f, input bit ph);
    if (cw[6]) return 8;
    if (!ph && (cw[4] || (cw[3] && f))) return 0;
    return lvl(cw[2:0]);
  endfunction

  task automatic trial(input bit [7:0] cw, input bit [NCHAR-1:0] fl, input int scale,
                       input string req);
    bit ph;
    ctrl = cw; flash = fl;
    tick(); tick();
    ph = blink_phase;
    for (int i = 0; i < NCHAR; i++) cnt[i] = 0;
    repeat (15 * scale) begin
      tick();
      for (int i = 0; i < NCHAR; i++) if (col_en[i]) cnt[i]++;
    end
    for (int i = 0; i < NCHAR; i++)
      chk(cnt[i] == exp_n(cw, fl[i], ph) * scale, req, cnt[i], exp_n(cw, fl[i], ph) * scale);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t0, fall, bad;
    logic [NCHAR-1:0] snap;
    logic sph;
    void'($urandom(32'd4242));
    repeat (4) tick();
    chk(col_en == '0, "R8 reset col_en", int'(col_en), 0);
    chk(mux_tick == 1'b0, "R8 reset strobe", int'(mux_tick), 0);
    chk(blink_phase == 1'b1, "R3 reset phase", int'(blink_phase), 1);
    rst = 1'b0; cyc = 0;

    while (!mux_tick) tick();
    chk(cyc == STRB, "R2 first strobe", cyc, STRB);
    t0 = cyc; tick();
    while (!mux_tick) tick();
    chk(cyc - t0 == STRB, "R2 strobe spacing", cyc - t0, STRB);
    while (blink_phase) tick();
    chk(cyc == STRB * 64 + 1, "R3 first fall", cyc, STRB * 64 + 1);
    fall = cyc;

    // dark half of the blink phase
    for (int c = 0; c < 8; c++) trial(8'(c), '0, 1, "R4 code");
    trial(8'h4F, 8'hFF, 1, "R7 lamp over blank and flash");
    trial(8'h53, 8'h3C, 1, "R7 lamp over blink");
    trial(8'h12, 8'h00, 1, "R6 blink dark");
    trial(8'h0A, 8'hA5, 1, "R5 flash selected chars");
    trial(8'h02, 8'hFF, 1, "R5 flash bits without enable");
    trial(8'hA1, 8'h00, 1, "R10 bits 5 and 7 ignored");
    for (int k = 0; k < 20; k++)
      trial(8'($urandom), NCHAR'($urandom), 1, "R4 R5 R6 R7 random dark half");

    while (!blink_phase) tick();
    chk(cyc - fall == STRB * 64, "R3 dark span", cyc - fall, STRB * 64);

    // visible half
    trial(8'h1A, 8'hFF, 1, "R5 R6 visible half");
    trial(8'hE4, 8'h0F, 1, "R10 visible half");
    for (int k = 0; k < 10; k++)
      trial(8'($urandom), NCHAR'($urandom), 1, "R4 R5 R6 R7 random visible half");

    // external clock source
    clk_sel = 1'b0; ext_run = 1'b1;
    repeat (12) tick();
    trial(8'h01, '0, 4, "R1 external frame");
    trial(8'h45, '0, 4, "R1 external lamp");
    while (!mux_tick) tick();
    t0 = cyc; tick();
    while (!mux_tick) tick();
    chk(cyc - t0 == STRB * 4, "R1 external strobe spacing", cyc - t0, STRB * 4);

    ext_run = 1'b0;
    ctrl = 8'h03;
    repeat (12) tick();
    snap = col_en; sph = blink_phase; bad = 0;
    repeat (200) begin
      tick();
      if (col_en != snap || mux_tick || blink_phase != sph) bad++;
    end
    chk(bad == 0, "R9 frozen outputs", bad, 0);

    clk_sel = 1'b1;
    trial(8'h03, '0, 1, "R1 internal source resumes");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule